// File: doc/BRIEF.md
# Timer Compare Toggle Output

This block holds two up-counting timers. Each timer has a compare register that can only be written, and a toggle output. A timer counts on every cycle where an external tick enable is high. On a counting tick where the count equals the compare value, three things happen:

- the counter returns to zero instead of incrementing;
- the output's toggle state flips;
- a one-cycle interrupt pulse is raised.

The output is therefore a square wave with an even duty cycle. Its half period is (compare value + 1) ticks, so its frequency is the tick rate divided by 2 × (compare value + 1).

A pair-mode input joins the two timers into one wide compare unit. Timer 1 becomes the upper half of the count and of the compare value, and the combined match drives channel 0's pin and interrupt. Each pin reaches the outside only while its pin-select bit is 1 and its PWM-enable bit is 0. While a pin is not selected it sits low and its toggle state is held at 0.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `tcmp_top`

## Requirements
- R1: After reset both counters read 0, both pins and both interrupts are low, and both compare registers hold all ones (255), so the first match of an unwritten timer in split mode comes on its 256th tick.
- R2: A counter changes only on cycles with `tick_en` high. With `tick_en` low, both counters hold their value.
- R3: In split mode (`pair_en`=0), on a tick where a counter equals its compare value the counter becomes 0 at that edge. On any other tick it increments by one.
- R4: `match_irq[c]` is high for exactly the one cycle after each matching tick of channel c. This happens whether or not the pin is selected.
- R5: While channel c is gated on, `cmp_pin[c]` inverts at each matching tick and at no other time. This gives a half period of (compare value + 1) ticks.
- R6: Channel c is gated on only when `pin_sel[c]`=1 and `pwm_en[c]`=0. While gated off, the pin is 0 and the toggle state is cleared, so after re-enable the pin starts low until the next match.
- R7: `dr_wr[c]`=1 loads `dr_wdata` into channel c's compare register at the clock edge. The counter is not disturbed, and matches use the new value from the next cycle.
- R8: If a compare value is written below the current count, the counter runs up to 255 and rolls over to 0 without a match, interrupt or toggle. It then matches on reaching the new value.
- R9: In pair mode (`pair_en`=1), the count is {`cnt1`,`cnt0`}. `cnt1` increments on a tick that rolls `cnt0` over from 255. A match of both halves against {compare 1, compare 0} clears both halves and drives channel 0's toggle and interrupt.
- R10: In pair mode, `cmp_pin[1]` and `match_irq[1]` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting tick enable from the prescaler |
| pair_en | input | 1 | 1 joins both timers into one wide compare |
| dr_wr | input | 2 | Per-channel compare register write strobe |
| dr_wdata | input | 8 | Compare value to write |
| pin_sel | input | 2 | Per-channel pin function select (1 = compare output) |
| pwm_en | input | 2 | Per-channel PWM enable (1 blocks the compare output) |
| cmp_pin | output | 2 | Toggle compare outputs |
| match_irq | output | 2 | One-cycle match interrupt pulses |
| cnt0 | output | 8 | Timer 0 count |
| cnt1 | output | 8 | Timer 1 count |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Compare value 255 after reset.** A design that matched early would pulse before the 256th tick.
- **Compare value written below the count.** A design comparing with greater-or-equal would fire immediately instead of wrapping through zero.
- **Carry from the low half in pair mode, and the combined match.** A design without the carry would never match. One that matched on the low half alone would pulse after the third tick.
- **Gating off and back on.** A design that kept the toggle state through gating would come back with the pin high. One that tied the interrupt to the gate would lose pulses while the pin is not selected.

// File: rtl/tcmp_pkg.sv
`timescale 1ns/1ps
package tcmp_pkg;
  localparam int unsigned TMR_W = 8;
  localparam int unsigned N_CH  = 2;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_PAIR  = 1'b1
  } pair_mode_e;
endpackage

// File: rtl/tcmp_slice.sv
`timescale 1ns/1ps
module tcmp_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dr_load,
  input  logic [W-1:0] dr_din,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] dr
);
  localparam logic [W-1:0] DR_RST = '1;
  localparam logic [W-1:0] ONE    = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr <= DR_RST;
    end else if (dr_load) begin
      dr <= dr_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + ONE;
    end
  end

  // R7
  dr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_load |=> $stable(dr));
endmodule

// File: rtl/tcmp_match.sv
`timescale 1ns/1ps
module tcmp_match
  import tcmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            tick,
  input  pair_mode_e      mode,
  input  logic [W-1:0]    cnt_lo,
  input  logic [W-1:0]    dr_lo,
  input  logic [W-1:0]    cnt_hi,
  input  logic [W-1:0]    dr_hi,
  output logic [N_CH-1:0] inc,
  output logic [N_CH-1:0] clr,
  output logic [N_CH-1:0] hit
);
  logic eq_lo, eq_hi, lo_full;

  assign eq_lo   = (cnt_lo == dr_lo);
  assign eq_hi   = (cnt_hi == dr_hi);
  assign lo_full = &cnt_lo;

  always_comb begin
    inc = '0;
    clr = '0;
    hit = '0;
    unique case (mode)
      MODE_PAIR: begin
        hit[0] = tick & eq_lo & eq_hi;
        hit[1] = 1'b0;
        clr[0] = hit[0];
        clr[1] = hit[0];
        inc[0] = tick;
        inc[1] = tick & lo_full;
      end
      default: begin
        hit[0] = tick & eq_lo;
        hit[1] = tick & eq_hi;
        clr    = hit;
        inc    = {N_CH{tick}};
      end
    endcase
  end
endmodule

// File: rtl/tcmp_pinout.sv
`timescale 1ns/1ps
module tcmp_pinout (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic gate_on,
  output logic pin,
  output logic irq
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (!gate_on) begin
      tog_q <= 1'b0;
    end else if (hit) begin
      tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= hit;
    end
  end

  assign pin = tog_q & gate_on;

  // R5
  pin_moves_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && $past(gate_on) && (pin != $past(pin))) |-> irq);

  // R6
  reenable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_on) && !irq) |-> !pin);
endmodule

// File: rtl/tcmp_top.sv
`timescale 1ns/1ps
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            pair_en,
  input  logic [N_CH-1:0] dr_wr,
  input  logic [W-1:0]    dr_wdata,
  input  logic [N_CH-1:0] pin_sel,
  input  logic [N_CH-1:0] pwm_en,
  output logic [N_CH-1:0] cmp_pin,
  output logic [N_CH-1:0] match_irq,
  output logic [W-1:0]    cnt0,
  output logic [W-1:0]    cnt1
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]    cnt_q [N_CH];
  logic [W-1:0]    dr_q  [N_CH];
  logic [N_CH-1:0] inc, clr, hit, gate;
  pair_mode_e      mode;

  assign mode = pair_en ? MODE_PAIR : MODE_SPLIT;

  // channel 1 output is parked while the timers run as a pair
  assign gate[0] = pin_sel[0] & ~pwm_en[0];
  assign gate[1] = pin_sel[1] & ~pwm_en[1] & ~pair_en;

  tcmp_match #(.W(W)) u_match (
    .tick   (tick_en),
    .mode   (mode),
    .cnt_lo (cnt_q[0]),
    .dr_lo  (dr_q[0]),
    .cnt_hi (cnt_q[1]),
    .dr_hi  (dr_q[1]),
    .inc    (inc),
    .clr    (clr),
    .hit    (hit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tcmp_slice #(.W(W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .dr_load (dr_wr[c]),
      .dr_din  (dr_wdata),
      .inc     (inc[c]),
      .clr     (clr[c]),
      .cnt     (cnt_q[c]),
      .dr      (dr_q[c])
    );

    tcmp_pinout u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit[c]),
      .gate_on (gate[c]),
      .pin     (cmp_pin[c]),
      .irq     (match_irq[c])
    );
  end

  assign cnt0 = cnt_q[0];
  assign cnt1 = cnt_q[1];

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt0) && $stable(cnt1)));

  // R3
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_en && tick_en) |=> ((cnt0 == $past(cnt0) + ONE) || (cnt0 == '0)));

  // R4
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq[0] |-> $past(tick_en));

  // R9
  pair_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en && tick_en && (&cnt0) && !((cnt0 == dr_q[0]) && (cnt1 == dr_q[1])))
      |=> (cnt1 == $past(cnt1) + ONE));

  // R10
  pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pair_en) && pair_en) |-> (!match_irq[1] && !cmp_pin[1]));
endmodule

// File: tb/test_tcmp_top.sv
`timescale 1ns/1ps
module test_tcmp_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, pair_en;
  logic [1:0] dr_wr, pin_sel, pwm_en, cmp_pin, match_irq;
  logic [7:0] dr_wdata, cnt0, cnt1;
  int checks = 0;
  int errors = 0;
  int irq0_seen, irq1_seen;

  always #2.5 clk = ~clk;

  tcmp_top i_tcmp_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pair_en(pair_en),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata), .pin_sel(pin_sel), .pwm_en(pwm_en),
    .cmp_pin(cmp_pin), .match_irq(match_irq), .cnt0(cnt0), .cnt1(cnt1)
  );

  // {tick, wr0, wdata[8], sel0, pwm0 | cnt0[8], pin0, irq0}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h03, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b0; pair_en = 1'b0; dr_wr = '0;
    dr_wdata = '0; pin_sel = '0; pwm_en = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      step();
      irq0_seen += int'(match_irq[0]);
      irq1_seen += int'(match_irq[1]);
    end
    tick_en = 1'b0;
  endtask

  task automatic write_dr(input int ch, input logic [7:0] v);
    dr_wr = '0; dr_wr[ch] = 1'b1; dr_wdata = v;
    step();
    dr_wr = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    // R1 reset state, compare register resets to 255
    do_reset();
    check("R1", "cnt0", cnt0, 0);
    check("R1", "cnt1", cnt1, 0);
    check("R1", "pins", cmp_pin, 0);
    check("R1", "irqs", match_irq, 0);
    pin_sel = 2'b10;
    irq1_seen = 0; irq0_seen = 0;
    run_ticks(255);
    check("R1", "cnt1 before 256th tick", cnt1, 255);
    check("R1", "irq1 before 256th tick", irq1_seen, 0);
    run_ticks(1);
    check("R1", "cnt1 after 256th tick", cnt1, 0);
    check("R1", "irq1 on 256th tick", match_irq[1], 1);
    check("R5", "pin1 after first match", cmp_pin[1], 1);

    // vector table: R2 R3 R4 R5 R6 R7 on channel 0
    do_reset();
    for (int k = 0; k < NV; k++) begin
      tick_en    = VEC[k][21];
      dr_wr      = {1'b0, VEC[k][20]};
      dr_wdata   = VEC[k][19:12];
      pin_sel[0] = VEC[k][11];
      pwm_en[0]  = VEC[k][10];
      step();
      check("R3", $sformatf("vec %0d cnt0", k), cnt0, int'(VEC[k][9:2]));
      check("R5", $sformatf("vec %0d pin0", k), cmp_pin[0], int'(VEC[k][1]));
      check("R4", $sformatf("vec %0d irq0", k), match_irq[0], int'(VEC[k][0]));
    end
    dr_wr = '0; tick_en = 1'b0;

    // R8 compare value written below current count
    do_reset();
    pin_sel = 2'b01;
    write_dr(0, 8'd5);
    irq0_seen = 0; irq1_seen = 0;
    run_ticks(4);
    write_dr(0, 8'd2);
    check("R7", "cnt0 kept on write", cnt0, 4);
    run_ticks(252);
    check("R8", "cnt0 rolled to zero", cnt0, 0);
    check("R8", "no irq while wrapping", irq0_seen, 0);
    check("R8", "pin0 unchanged while wrapping", cmp_pin[0], 0);
    run_ticks(3);
    check("R8", "match after wrap irq count", irq0_seen, 1);
    check("R8", "pin0 after match", cmp_pin[0], 1);

    // R6 gating clears toggle state
    do_reset();
    pin_sel = 2'b01;
    write_dr(0, 8'd1);
    run_ticks(2);
    check("R6", "pin0 high after match", cmp_pin[0], 1);
    pwm_en[0] = 1'b1;
    step();
    check("R6", "pin0 low with pwm enabled", cmp_pin[0], 0);
    pwm_en[0] = 1'b0;
    step();
    check("R6", "pin0 starts low on re-enable", cmp_pin[0], 0);
    run_ticks(2);
    check("R6", "pin0 high on next match", cmp_pin[0], 1);

    // R9 R10 pair mode
    do_reset();
    pair_en = 1'b1; pin_sel = 2'b11;
    write_dr(0, 8'h02);
    write_dr(1, 8'h01);
    irq0_seen = 0; irq1_seen = 0;
    run_ticks(256);
    check("R9", "cnt1 carry", cnt1, 1);
    check("R9", "cnt0 rolled", cnt0, 0);
    run_ticks(2);
    check("R9", "cnt0 at target", cnt0, 2);
    check("R9", "no early match", irq0_seen, 0);
    run_ticks(1);
    check("R9", "cnt0 cleared", cnt0, 0);
    check("R9", "cnt1 cleared", cnt1, 0);
    check("R9", "irq0 on pair match", match_irq[0], 1);
    check("R9", "pin0 toggled", cmp_pin[0], 1);
    check("R10", "pin1 parked", cmp_pin[1], 0);
    check("R10", "irq1 silent", irq1_seen, 0);

    finish_run();
  end
endmodule